// File: doc/BRIEF.md
# Section Translation Walker

This block resolves a 32-bit virtual address into a 40-bit physical address for memory that is mapped in 1 MB sections. Each translation needs exactly one fetch from the first-level table. The caller supplies the virtual address, two table base values and a 3-bit split value. The walker chooses one of the two bases and builds the word address of the descriptor. It issues a single read on a plain request/response memory port and waits for the answer.

When the returned word is a section descriptor, the walker combines its upper bits with the low 20 bits of the virtual address. It then presents the physical address together with the descriptor's control bits, which a later stage uses for permission checks. Any other descriptor type produces a translation fault. The walker handles one translation at a time. Its result appears on a registered output for a single cycle.

Top module: `sect_xlate_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_va`, `tbl_base0`, `tbl_base1` and `split_n` are sampled on that edge.
- R2: The second base (`out_base_sel`=1) is chosen when `split_n` is nonzero and at least one of virtual address bits [31:32-split_n] is 1. In every other case the first base is chosen (`out_base_sel`=0).
- R3: With the first base, the effective split k equals `split_n`. The fetch address is the chosen base with bits [13-k:0] cleared, ORed with va[31-k:20] placed at bits [13-k:2]. Bits [1:0] are 0.
- R4: With the second base, k is forced to 0. The fetch address is then base[31:14] followed by va[31:20] and then 2'b00.
- R5: `mem_rd_req` is high for exactly one cycle, the cycle after acceptance, with `mem_rd_addr` valid in that cycle. The walker then waits any number of cycles for `mem_rd_vld`. A `mem_rd_vld` seen in any cycle other than the waiting cycles is ignored.
- R6: A descriptor whose bits [1:0] are 2'b10 is a section. In that case `out_fault`=0, `out_pa`[31:20] = descriptor[31:20], `out_pa`[19:0] = va[19:0], and `out_pa`[39:32] = 8'h00.
- R7: Descriptor bits [1:0] of 2'b00, 2'b01 or 2'b11 give `out_fault`=1, with `out_pa` and `out_attr` driven to zero.
- R8: On a section, `out_attr` carries descriptor bits [19:2] unchanged.
- R9: `out_valid` is high for exactly one cycle, the cycle after the edge that takes `mem_rd_vld`. The walker is already idle and ready in that cycle.
- R10: The synchronous active-high `rst` returns the walker to idle from any state: `req_ready`=1, `mem_rd_req`=0, `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, can take a request |
| req_va | input | 32 | Virtual address to translate |
| tbl_base0 | input | 32 | First table base |
| tbl_base1 | input | 32 | Second table base |
| split_n | input | 3 | Split value selecting index width |
| mem_rd_req | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_vld | input | 1 | Read data present |
| mem_rd_data | input | 32 | Returned descriptor |
| out_valid | output | 1 | Result present for one cycle |
| out_fault | output | 1 | Descriptor was not a section |
| out_pa | output | 40 | Physical address |
| out_attr | output | 18 | Descriptor control bits [19:2] |
| out_base_sel | output | 1 | 1 when the second base was used |

## Verification
The bound checker watches several properties on every cycle. The read request and the result pulse must each last a single cycle. The request must never overlap readiness. The fetch address must stay word aligned. Every section result must have zero upper bits and carry the offset of the accepted address, and a fault must come with a zeroed address. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These include base selection for each split value and the masking of base and index bits. They also cover the variable response latency, stray read-valid pulses outside the waiting window, back-to-back requests and reset during a walk.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 40;
  localparam int DESC_W   = 32;
  localparam int N_W      = 3;
  localparam int SECT_LSB = 20;
  localparam int IDX_W    = VA_W - SECT_LSB;
  localparam int ATTR_W   = SECT_LSB - 2;
  localparam int TBL_LSB  = IDX_W + 2;
  localparam logic [1:0] SECTION_CODE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_t;

  typedef struct packed {
    logic              fault;
    logic [PA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
  } walk_result_t;
endpackage

// File: rtl/sxw_base_select.sv
module sxw_base_select
  import sxw_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] base0,
  input  logic [VA_W-1:0] base1,
  input  logic [N_W-1:0]  n_in,
  output logic            use_second,
  output logic [VA_W-1:0] base_out,
  output logic [N_W-1:0]  n_eff
);
  logic [VA_W-1:0] top_mask;
  logic            top_hit;

  // top n bits of the address set in the mask
  assign top_mask   = ~({VA_W{1'b1}} >> n_in);
  assign top_hit    = |(va & top_mask);
  assign use_second = (n_in != '0) && top_hit;
  assign base_out   = use_second ? base1 : base0;
  assign n_eff      = use_second ? '0 : n_in;
endmodule

// File: rtl/sxw_desc_addr.sv
module sxw_desc_addr
  import sxw_pkg::*;
(
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] va,
  input  logic [N_W-1:0]  n_eff,
  output logic [VA_W-1:0] fetch_addr
);
  logic [VA_W-1:0]  base_mask;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] idx;

  assign base_mask  = {VA_W{1'b1}} << (TBL_LSB - int'(n_eff));
  assign idx_mask   = {IDX_W{1'b1}} >> n_eff;
  assign idx        = va[VA_W-1:SECT_LSB] & idx_mask;
  assign fetch_addr = (base & base_mask) |
                      {{(VA_W-IDX_W-2){1'b0}}, idx, 2'b00};
endmodule

// File: rtl/sxw_desc_decode.sv
module sxw_desc_decode
  import sxw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [VA_W-1:0]   va,
  output walk_result_t      result
);
  logic is_section;

  assign is_section = (desc[1:0] == SECTION_CODE);

  always_comb begin
    result = '0;
    if (is_section) begin
      result.fault = 1'b0;
      result.pa    = {{(PA_W-VA_W){1'b0}},
                      desc[DESC_W-1:SECT_LSB], va[SECT_LSB-1:0]};
      result.attr  = desc[SECT_LSB-1:2];
    end else begin
      result.fault = 1'b1;
    end
  end
endmodule

// File: rtl/sect_xlate_walker.sv
module sect_xlate_walker
  import sxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [VA_W-1:0]   tbl_base0,
  input  logic [VA_W-1:0]   tbl_base1,
  input  logic [N_W-1:0]    split_n,
  output logic              mem_rd_req,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_vld,
  input  logic [DESC_W-1:0] mem_rd_data,
  output logic              out_valid,
  output logic              out_fault,
  output logic [PA_W-1:0]   out_pa,
  output logic [ATTR_W-1:0] out_attr,
  output logic              out_base_sel
);
  walk_state_t     state_q;
  logic [VA_W-1:0] va_q;
  logic            sel_q;
  logic            accept;
  logic            take_rsp;

  logic            sel_c;
  logic [VA_W-1:0] base_c;
  logic [N_W-1:0]  neff_c;
  logic [VA_W-1:0] addr_c;
  walk_result_t    res_c;

  sxw_base_select u_sel (
    .va(req_va), .base0(tbl_base0), .base1(tbl_base1), .n_in(split_n),
    .use_second(sel_c), .base_out(base_c), .n_eff(neff_c)
  );

  sxw_desc_addr u_addr (
    .base(base_c), .va(req_va), .n_eff(neff_c), .fetch_addr(addr_c)
  );

  sxw_desc_decode u_dec (
    .desc(mem_rd_data), .va(va_q), .result(res_c)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign take_rsp  = (state_q == ST_WAIT) && mem_rd_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_rd_req <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      mem_rd_req <= accept;
      out_valid  <= take_rsp;
      unique case (state_q)
        ST_IDLE: if (accept)   state_q <= ST_REQ;
        ST_REQ:                state_q <= ST_WAIT;
        ST_WAIT: if (take_rsp) state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q         <= '0;
      sel_q        <= 1'b0;
      mem_rd_addr  <= '0;
      out_fault    <= 1'b0;
      out_pa       <= '0;
      out_attr     <= '0;
      out_base_sel <= 1'b0;
    end else begin
      if (accept) begin
        va_q        <= req_va;
        sel_q       <= sel_c;
        mem_rd_addr <= addr_c;
      end
      if (take_rsp) begin
        out_fault    <= res_c.fault;
        out_pa       <= res_c.pa;
        out_attr     <= res_c.attr;
        out_base_sel <= sel_q;
      end
    end
  end
endmodule

// File: rtl/sxw_checker.sv
module sxw_checker
  import sxw_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            mem_rd_req,
  input logic [VA_W-1:0] mem_rd_addr,
  input logic            out_valid,
  input logic            out_fault,
  input logic [PA_W-1:0] out_pa
);
  logic [VA_W-1:0] cap_va;

  always_ff @(posedge clk) begin
    if (rst) cap_va <= '0;
    else if (req_valid && req_ready) cap_va <= req_va;
  end

  a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  a_r5_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r9_ready_at_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> req_ready);

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pa[PA_W-1:VA_W] == '0));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |-> (out_pa[SECT_LSB-1:0] == cap_va[SECT_LSB-1:0]));

  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_pa == '0));
endmodule

bind sect_xlate_walker sxw_checker u_sxw_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
  .out_valid(out_valid), .out_fault(out_fault), .out_pa(out_pa)
);

// File: tb/sect_xlate_walker_tb_top.sv
module sect_xlate_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] tbl_base0 = '0;
  logic [31:0] tbl_base1 = '0;
  logic [2:0]  split_n = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_vld = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        out_valid;
  logic        out_fault;
  logic [39:0] out_pa;
  logic [17:0] out_attr;
  logic        out_base_sel;

  always #2 clk = ~clk;

  sect_xlate_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tbl_base0(tbl_base0), .tbl_base1(tbl_base1),
    .split_n(split_n), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_fault(out_fault), .out_pa(out_pa),
    .out_attr(out_attr), .out_base_sel(out_base_sel)
  );

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  int          m_phase = 0;
  longint      m_va, m_addr;
  bit          m_sel;
  bit          e_out_v;
  bit          e_fault;
  bit          e_sel;
  longint      e_pa, e_attr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    e_out_v = 1'b0;
    if (rst) begin
      m_phase = 0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
          longint va, b, n, hi, idx;
          va = longint'(req_va);
          n  = longint'(split_n);
          hi = (n == 0) ? 0 : (va >> (32 - n));
          if (n != 0 && hi != 0) begin
            m_sel = 1'b1; b = longint'(tbl_base1); n = 0;
          end else begin
            m_sel = 1'b0; b = longint'(tbl_base0);
          end
          idx    = (va >> 20) % (longint'(1) << (12 - n));
          m_addr = ((b >> (14 - n)) << (14 - n)) + idx * 4;
          m_va   = va;
          m_phase = 1;
        end
        1: m_phase = 2;
        default: if (mem_rd_vld) begin
          longint d;
          d = longint'(mem_rd_data);
          e_out_v = 1'b1;
          e_sel   = m_sel;
          if ((d % 4) == 2) begin
            e_fault = 1'b0;
            e_pa    = ((d >> 20) << 20) + (m_va % (longint'(1) << 20));
            e_attr  = (d >> 2) % (longint'(1) << 18);
          end else begin
            e_fault = 1'b1; e_pa = 0; e_attr = 0;
          end
          m_phase = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(req_ready == (m_phase == 0), "R1", "req_ready", req_ready, m_phase == 0);
      chk(mem_rd_req == (m_phase == 1), "R5", "mem_rd_req", mem_rd_req, m_phase == 1);
      if (m_phase == 1)
        chk(longint'(mem_rd_addr) == m_addr, m_sel ? "R4" : "R3", "mem_rd_addr",
            mem_rd_addr, m_addr);
      chk(out_valid == e_out_v, "R9", "out_valid", out_valid, e_out_v);
      if (e_out_v) begin
        chk(out_base_sel == e_sel, "R2", "out_base_sel", out_base_sel, e_sel);
        chk(out_fault == e_fault, e_fault ? "R7" : "R6", "out_fault", out_fault, e_fault);
        chk(longint'(out_pa) == e_pa, e_fault ? "R7" : "R6", "out_pa", out_pa, e_pa);
        chk(longint'(out_attr) == e_attr, e_fault ? "R7" : "R8", "out_attr", out_attr, e_attr);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // one translation; stray_req pulses read-valid during the request cycle
  task automatic walk(input logic [31:0] va, input logic [31:0] b0,
                      input logic [31:0] b1, input logic [2:0] n,
                      input logic [31:0] desc, input int delay,
                      input bit stray_req);
    req_valid = 1'b1; req_va = va; tbl_base0 = b0; tbl_base1 = b1; split_n = n;
    @(posedge clk); #1;
    while (!(req_ready === 1'b0)) begin @(posedge clk); #1; end
    req_valid = 1'b0;
    req_va = $urandom; tbl_base0 = $urandom; split_n = 3'($urandom);
    if (stray_req) begin mem_rd_vld = 1'b1; mem_rd_data = 32'hFFFF_FFF2; end
    repeat (delay) begin @(posedge clk); #1; mem_rd_vld = 1'b0; end
    mem_rd_vld = 1'b1; mem_rd_data = desc;
    @(posedge clk); #1;
    mem_rd_vld = 1'b0; mem_rd_data = $urandom;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: reset state
    chk(req_ready === 1'b1, "R10", "req_ready after reset", req_ready, 1);
    chk(mem_rd_req === 1'b0, "R10", "mem_rd_req after reset", mem_rd_req, 0);
    chk(out_valid === 1'b0, "R10", "out_valid after reset", out_valid, 0);
    cmp_on = 1'b1;

    // R5: stray read-valid while idle is ignored
    mem_rd_vld = 1'b1; mem_rd_data = 32'h1234_5672;
    @(posedge clk); #1 mem_rd_vld = 1'b0;
    @(posedge clk); #1;

    // R3 k=0, base low bits ignored; R6/R8 section
    walk(32'hABC1_2345, 32'h1234_7FFF, 32'h0, 3'd0, 32'hFED0_0C0E, 1, 1'b0);
    // R3 k=3 with top bits clear
    walk(32'h1FF5_4321, 32'h8000_3FFF, 32'h5555_0000, 3'd3, 32'h0010_0002, 2, 1'b0);
    // R2/R4 k forced 0
    walk(32'h2FF5_4321, 32'h8000_3FFF, 32'h5555_FFFF, 3'd3, 32'h0020_FFFE, 1, 1'b1);
    // R2 n=7 edges
    walk(32'h0200_0000, 32'hFFFF_FFFF, 32'h0000_4000, 3'd7, 32'hA000_0002, 4, 1'b0);
    walk(32'h01FF_FFFF, 32'hFFFF_FFFF, 32'h0000_4000, 3'd7, 32'hA000_0002, 1, 1'b0);
    walk(32'h8000_0000, 32'h0, 32'hC000_0000, 3'd1, 32'h1230_0002, 3, 1'b0);
    // R7 faults
    walk(32'h0000_1000, 32'h4000, 32'h0, 3'd0, 32'hFFFF_FFFC, 1, 1'b0);
    walk(32'h0000_1000, 32'h4000, 32'h0, 3'd0, 32'hFFFF_FFFD, 2, 1'b0);
    walk(32'h0000_1000, 32'h4000, 32'h0, 3'd0, 32'hFFFF_FFFF, 9, 1'b1);

    // R10: reset in the waiting window
    req_valid = 1'b1; req_va = 32'h1; split_n = 3'd0;
    @(posedge clk); #1 req_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    chk(req_ready === 1'b1 && mem_rd_req === 1'b0 && out_valid === 1'b0,
        "R10", "idle after mid-walk reset", {req_ready, mem_rd_req, out_valid}, 3'b100);
    @(posedge clk); #1;

    for (int i = 0; i < 60; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (i % 3 != 0) d[1:0] = 2'b10;
      walk($urandom, $urandom, $urandom, 3'($urandom), d,
           1 + int'($urandom % 5), 1'($urandom));
    end
    repeat (4) @(posedge clk);
    #1 finish_run();
  end
endmodule